// File: doc/BRIEF.md
# Channel Fault Recovery Sequencer

This block decides what one LED sink channel does after its fault qualifier has confirmed a problem. It shuts the channel off, then either schedules recovery attempts or keeps the channel lit at a reduced level. Recovery attempts are spaced by a programmable interval and are made only while the temperature and supply monitors both report healthy. A bounded attempt budget ends in a latched shutdown. That latch clears through a service request or, if configured, on its own once conditions recover.

Every state change produces a one-cycle log record for an external recorder. The record holds the fault code, a free-running cycle timestamp, the attempt count, the action taken and the state that was left. An interrupt pulse marks only the two events that need attention: a newly confirmed fault and the move into the latch.

State encoding used throughout: normal run = 0, fault confirmed = 1, retry wait = 2, degraded run = 3, latched = 4. Action encoding in the log: resume = 0, shutdown = 1, back-off = 2, re-enable = 3, derate = 4, latch = 5.

Top module: `fault_resp_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it is released, the state is normal run (0), the channel enable is 1, derate is 0, irq is 0 and no log record is valid.
- R2: Normal run moves to fault confirmed (1) on the clock edge that samples fault_confirm high, and only then. In that next cycle the enable is 0, irq pulses, and the log shows action shutdown (1), the incoming fault code and the current attempt count.
- R3: Fault confirmed lasts exactly one cycle. With policy_degrade set it moves to degraded run (3), where the enable is 1 and derate is 1, logging derate (4). Otherwise it moves to retry wait (2) when the attempt count is below max_attempts, logging back-off (2) with irq low.
- R4: Retry wait keeps the channel off. It moves back to normal run on the first edge at which at least retry_interval cycles have passed in the state and temp_ok and v_ok are both high. With both monitors healthy throughout, the state lasts retry_interval+1 cycles.
- R5: Each exit from retry wait adds one to the attempt count and logs re-enable (3). A fault confirmed within the first hold_window+1 cycles after re-enable keeps the count. Staying in normal run longer than that returns the count to 0.
- R6: When fault confirmed is reached with the attempt count equal to max_attempts and the retry policy selected, the next state is latched (4) with the enable 0, irq pulsed and action latch (5) logged. max_attempts of 0 latches on the first fault.
- R7: Latched moves to normal run (logging resume, 0, with count 0) on svc_clear. When auto_recover is set, it also moves once at least retry_interval cycles have passed in the state with temp_ok and v_ok both high, which takes retry_interval+1 cycles when healthy.
- R8: Degraded run ignores fault_confirm and leaves only on svc_clear, returning to normal run with derate 0. svc_clear has no effect in normal run or retry wait.
- R9: A log record is valid for exactly the one cycle in which a new state is first shown. It carries the state that was left and a timestamp equal to the number of clock edges since reset release, counted before the transition edge. No record appears otherwise.
- R10: irq is high for one cycle on entry to fault confirmed or latched and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_confirm | input | 1 | Fault confirmed by the upstream qualifier |
| fault_code | input | CODE_W | Class of the confirmed fault |
| temp_ok | input | 1 | Temperature within the safe region |
| v_ok | input | 1 | Supply headroom within the safe region |
| policy_degrade | input | 1 | 1: derate and continue, 0: retry |
| auto_recover | input | 1 | Allows the latch to clear on health |
| svc_clear | input | 1 | Service clear request |
| retry_interval | input | TMR_W | Minimum cycles spent in retry wait and auto latch exit |
| hold_window | input | TMR_W | Span after re-enable within which a fault counts as a failed attempt |
| max_attempts | input | ATT_W | Attempt budget before latching |
| ch_enable | output | 1 | Channel sink enable |
| derate_req | output | 1 | Reduced-level request |
| state_o | output | 3 | Current state code |
| irq | output | 1 | Attention pulse |
| log_valid | output | 1 | Log record strobe |
| log_code | output | CODE_W | Fault code of the record |
| log_time | output | TS_W | Timestamp of the record |
| log_count | output | ATT_W | Attempt count after the transition |
| log_action | output | 3 | Action code of the record |
| log_state | output | 3 | State that was left |

## Verification
The bench sweeps every pairing of an attempt budget from 0 to 3 and a retry interval from 0 to 3. It runs fault after fault until the latch, which separates off-by-one errors in the budget comparison from errors in the interval timing. Further patterns use a faulting monitor held low across an expired interval to show that health gates the exit, not time alone. A fault placed on the last cycle of the hold window and another placed one cycle later tell a kept attempt count from a cleared one. The degraded path, stray clear requests and the automatic latch exit show which inputs each state must ignore.

// File: rtl/fault_resp_pkg.sv
package fault_resp_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL   = 3'd0,
        ST_FAULT    = 3'd1,
        ST_RETRY    = 3'd2,
        ST_DEGRADED = 3'd3,
        ST_LATCHED  = 3'd4
    } resp_state_t;

    typedef enum logic [2:0] {
        ACT_RESUME   = 3'd0,
        ACT_SHUTDOWN = 3'd1,
        ACT_BACKOFF  = 3'd2,
        ACT_REENABLE = 3'd3,
        ACT_DERATE   = 3'd4,
        ACT_LATCH    = 3'd5
    } resp_action_t;

    // One cycle's decision of the sequencer
    typedef struct packed {
        resp_state_t nxt;
        logic        att_inc;
        logic        att_clr;
        logic        hold_start;
    } resp_step_t;

    localparam int DEF_CODE_W = 4;
    localparam int DEF_TMR_W  = 8;
    localparam int DEF_ATT_W  = 3;
    localparam int DEF_TS_W   = 16;

    function automatic resp_action_t action_for(resp_state_t from_st, resp_state_t to_st);
        resp_action_t a;
        case (to_st)
            ST_NORMAL:   a = (from_st == ST_RETRY) ? ACT_REENABLE : ACT_RESUME;
            ST_FAULT:    a = ACT_SHUTDOWN;
            ST_RETRY:    a = ACT_BACKOFF;
            ST_DEGRADED: a = ACT_DERATE;
            ST_LATCHED:  a = ACT_LATCH;
            default:     a = ACT_RESUME;
        endcase
        return a;
    endfunction

    function automatic logic output_on(resp_state_t s);
        return (s == ST_NORMAL) || (s == ST_DEGRADED);
    endfunction

    function automatic logic raises_irq(resp_state_t s);
        return (s == ST_FAULT) || (s == ST_LATCHED);
    endfunction

endpackage

// File: rtl/fault_resp_timer.sv
module fault_resp_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         done
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q >= limit);

endmodule

// File: rtl/fault_resp_attempts.sv
module fault_resp_attempts #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count,
    output logic [W-1:0] count_next
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_q;

    always_comb begin
        count_next = cnt_q;
        if (clr) begin
            count_next = '0;
        end else if (inc && (cnt_q != CNT_MAX)) begin
            count_next = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= count_next;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/fault_resp_log.sv
module fault_resp_log
    import fault_resp_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W,
    parameter int ATT_W  = DEF_ATT_W,
    parameter int TS_W   = DEF_TS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              irq_evt,
    input  logic [CODE_W-1:0] code,
    input  logic [ATT_W-1:0]  count,
    input  resp_action_t      action,
    input  resp_state_t       from_st,
    output logic              irq,
    output logic              log_valid,
    output logic [CODE_W-1:0] log_code,
    output logic [TS_W-1:0]   log_time,
    output logic [ATT_W-1:0]  log_count,
    output logic [2:0]        log_action,
    output logic [2:0]        log_state
);
    logic [TS_W-1:0] ts_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_q <= '0;
        end else begin
            ts_q <= ts_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq        <= 1'b0;
            log_valid  <= 1'b0;
            log_code   <= '0;
            log_time   <= '0;
            log_count  <= '0;
            log_action <= '0;
            log_state  <= '0;
        end else begin
            irq       <= irq_evt;
            log_valid <= fire;
            if (fire) begin
                log_code   <= code;
                log_time   <= ts_q;
                log_count  <= count;
                log_action <= action;
                log_state  <= from_st;
            end
        end
    end

endmodule

// File: rtl/fault_resp_ctrl.sv
module fault_resp_ctrl
    import fault_resp_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W,
    parameter int TMR_W  = DEF_TMR_W,
    parameter int ATT_W  = DEF_ATT_W,
    parameter int TS_W   = DEF_TS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fault_confirm,
    input  logic [CODE_W-1:0] fault_code,
    input  logic              temp_ok,
    input  logic              v_ok,
    input  logic              policy_degrade,
    input  logic              auto_recover,
    input  logic              svc_clear,
    input  logic [TMR_W-1:0]  retry_interval,
    input  logic [TMR_W-1:0]  hold_window,
    input  logic [ATT_W-1:0]  max_attempts,
    output logic              ch_enable,
    output logic              derate_req,
    output logic [2:0]        state_o,
    output logic              irq,
    output logic              log_valid,
    output logic [CODE_W-1:0] log_code,
    output logic [TS_W-1:0]   log_time,
    output logic [ATT_W-1:0]  log_count,
    output logic [2:0]        log_action,
    output logic [2:0]        log_state
);
    resp_state_t       st_q;
    resp_step_t        step;
    logic              healthy;
    logic              moving;
    logic              wait_done;
    logic              hold_done;
    logic              hold_active_q;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] rec_code;
    logic [ATT_W-1:0]  att_q;
    logic [ATT_W-1:0]  att_next;

    assign healthy = temp_ok && v_ok;

    // Next-state decision
    always_comb begin
        step.nxt        = st_q;
        step.att_inc    = 1'b0;
        step.att_clr    = 1'b0;
        step.hold_start = 1'b0;
        unique case (st_q)
            ST_NORMAL: begin
                if (fault_confirm) begin
                    step.nxt = ST_FAULT;
                end else if (hold_active_q && hold_done) begin
                    step.att_clr = 1'b1;
                end
            end
            ST_FAULT: begin
                if (policy_degrade) begin
                    step.nxt = ST_DEGRADED;
                end else if (att_q >= max_attempts) begin
                    step.nxt = ST_LATCHED;
                end else begin
                    step.nxt = ST_RETRY;
                end
            end
            ST_RETRY: begin
                if (wait_done && healthy) begin
                    step.nxt        = ST_NORMAL;
                    step.att_inc    = 1'b1;
                    step.hold_start = 1'b1;
                end
            end
            ST_DEGRADED: begin
                if (svc_clear) begin
                    step.nxt     = ST_NORMAL;
                    step.att_clr = 1'b1;
                end
            end
            ST_LATCHED: begin
                if (svc_clear || (auto_recover && wait_done && healthy)) begin
                    step.nxt     = ST_NORMAL;
                    step.att_clr = 1'b1;
                end
            end
            default: begin
                step.nxt = ST_NORMAL;
            end
        endcase
    end

    assign moving   = (step.nxt != st_q);
    assign rec_code = (st_q == ST_NORMAL) ? fault_code : code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q          <= ST_NORMAL;
            code_q        <= '0;
            hold_active_q <= 1'b0;
        end else begin
            st_q <= step.nxt;
            if ((st_q == ST_NORMAL) && fault_confirm) begin
                code_q <= fault_code;
            end
            if (step.hold_start) begin
                hold_active_q <= 1'b1;
            end else if (step.att_clr || (moving && (st_q == ST_NORMAL))) begin
                hold_active_q <= 1'b0;
            end
        end
    end

    // Time spent in the current state
    fault_resp_timer #(.W(TMR_W)) u_wait (
        .clk     (clk),
        .rst     (rst),
        .restart (moving),
        .limit   (retry_interval),
        .done    (wait_done)
    );

    // Time since the last re-enable
    fault_resp_timer #(.W(TMR_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .restart (step.hold_start),
        .limit   (hold_window),
        .done    (hold_done)
    );

    fault_resp_attempts #(.W(ATT_W)) u_att (
        .clk        (clk),
        .rst        (rst),
        .inc        (step.att_inc),
        .clr        (step.att_clr),
        .count      (att_q),
        .count_next (att_next)
    );

    fault_resp_log #(
        .CODE_W (CODE_W),
        .ATT_W  (ATT_W),
        .TS_W   (TS_W)
    ) u_log (
        .clk        (clk),
        .rst        (rst),
        .fire       (moving),
        .irq_evt    (moving && raises_irq(step.nxt)),
        .code       (rec_code),
        .count      (att_next),
        .action     (action_for(st_q, step.nxt)),
        .from_st    (st_q),
        .irq        (irq),
        .log_valid  (log_valid),
        .log_code   (log_code),
        .log_time   (log_time),
        .log_count  (log_count),
        .log_action (log_action),
        .log_state  (log_state)
    );

    assign state_o    = st_q;
    assign ch_enable  = output_on(st_q);
    assign derate_req = (st_q == ST_DEGRADED);

endmodule

// File: rtl/fault_resp_chk.sv
module fault_resp_chk (
    input logic       clk,
    input logic       rst,
    input logic       fault_confirm,
    input logic       temp_ok,
    input logic       v_ok,
    input logic       auto_recover,
    input logic       svc_clear,
    input logic [2:0] state_o,
    input logic       irq,
    input logic       log_valid,
    input logic [2:0] log_state
);
    // R2: normal run is left only on a confirmed fault
    a_r2_stay_normal: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd0 && !fault_confirm) |=> state_o == 3'd0);

    // R3: fault confirmed is a single-cycle decision state
    a_r3_fault_brief: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd1) |=> (state_o == 3'd2 || state_o == 3'd3 || state_o == 3'd4));

    // R4: no retry while either monitor reports trouble
    a_r4_retry_gated: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd2 && !(temp_ok && v_ok)) |=> state_o == 3'd2);

    // R7: latch without auto recovery waits for service
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd4 && !svc_clear && !auto_recover) |=> state_o == 3'd4);

    // R8: degraded run waits for service
    a_r8_degraded_hold: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd3 && !svc_clear) |=> state_o == 3'd3);

    // R9: a record accompanies every state change and nothing else
    a_r9_log_on_change: assert property (@(posedge clk) disable iff (rst)
        !$stable(state_o) |-> log_valid);

    a_r9_log_only_change: assert property (@(posedge clk) disable iff (rst)
        log_valid |-> !$stable(state_o));

    a_r9_log_from: assert property (@(posedge clk) disable iff (rst)
        log_valid |-> log_state == $past(state_o));

    // R10: attention pulse only on entry to fault or latch
    a_r10_irq_entry: assert property (@(posedge clk) disable iff (rst)
        irq |-> (log_valid && (state_o == 3'd1 || state_o == 3'd4)));

endmodule

bind fault_resp_ctrl fault_resp_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .fault_confirm (fault_confirm),
    .temp_ok       (temp_ok),
    .v_ok          (v_ok),
    .auto_recover  (auto_recover),
    .svc_clear     (svc_clear),
    .state_o       (state_o),
    .irq           (irq),
    .log_valid     (log_valid),
    .log_state     (log_state)
);

// File: tb/fault_resp_ctrl_test.sv
module fault_resp_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int S_NORMAL = 0, S_FAULT = 1, S_RETRY = 2, S_DEGR = 3, S_LATCH = 4;
    localparam int A_RESUME = 0, A_SHUT = 1, A_BACKOFF = 2, A_REEN = 3, A_DERATE = 4, A_LATCH = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fault_confirm = 1'b0;
    logic [3:0] fault_code = 4'd0;
    logic       temp_ok = 1'b1;
    logic       v_ok = 1'b1;
    logic       policy_degrade = 1'b0;
    logic       auto_recover = 1'b0;
    logic       svc_clear = 1'b0;
    logic [7:0] retry_interval = 8'd0;
    logic [7:0] hold_window = 8'd8;
    logic [2:0] max_attempts = 3'd0;
    logic       ch_enable, derate_req, irq, log_valid;
    logic [2:0] state_o, log_action, log_state, log_count;
    logic [3:0] log_code;
    logic [15:0] log_time;

    int checks = 0;
    int errors = 0;
    int bcyc = 0;
    int edge_ts = 0;
    int prev_st = 0;

    fault_resp_ctrl uut (
        .clk(clk), .rst(rst), .fault_confirm(fault_confirm), .fault_code(fault_code),
        .temp_ok(temp_ok), .v_ok(v_ok), .policy_degrade(policy_degrade),
        .auto_recover(auto_recover), .svc_clear(svc_clear),
        .retry_interval(retry_interval), .hold_window(hold_window),
        .max_attempts(max_attempts), .ch_enable(ch_enable), .derate_req(derate_req),
        .state_o(state_o), .irq(irq), .log_valid(log_valid), .log_code(log_code),
        .log_time(log_time), .log_count(log_count), .log_action(log_action),
        .log_state(log_state)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        fault_confirm = 1'b0;
        svc_clear = 1'b0;
        temp_ok = 1'b1;
        v_ok = 1'b1;
        policy_degrade = 1'b0;
        auto_recover = 1'b0;
        repeat (2) step();
        rst = 1'b0;
        step();
    endtask

    task automatic pulse_fault(input int code);
        fault_confirm = 1'b1;
        fault_code = 4'(code);
        step();
        fault_confirm = 1'b0;
    endtask

    task automatic wait_leave(input int st, output int n);
        n = 0;
        while (int'(state_o) == st && n < 400) begin
            step();
            n++;
        end
    endtask

    // Timestamp reference: edges since reset release, before the edge
    always @(posedge clk) begin
        if (rst) begin
            bcyc <= 0;
        end else begin
            edge_ts <= bcyc;
            bcyc <= bcyc + 1;
        end
    end

    // R9 record monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (int'(state_o) != prev_st) begin
                check("R9", "log_valid on change", int'(log_valid), 1);
                check("R9", "log_state", int'(log_state), prev_st);
                check("R9", "log_time", int'(log_time), edge_ts & 16'hFFFF);
            end else if (log_valid) begin
                check("R9", "log_valid without change", int'(log_valid), 0);
            end
        end
        prev_st = int'(state_o);
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog R1 run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        // Sweep attempt budget and interval up to the latch
        for (int m = 0; m <= 3; m++) begin
            for (int iv = 0; iv <= 3; iv++) begin
                max_attempts = 3'(m);
                retry_interval = 8'(iv);
                hold_window = 8'd8;
                do_reset();
                check("R1", "reset state", int'(state_o), S_NORMAL);
                check("R1", "reset enable", int'(ch_enable), 1);
                check("R1", "reset derate", int'(derate_req), 0);
                check("R1", "reset irq", int'(irq), 0);
                check("R1", "reset log_valid", int'(log_valid), 0);
                for (int a = 0; a <= m; a++) begin
                    pulse_fault(a + m);
                    check("R2", "fault state", int'(state_o), S_FAULT);
                    check("R2", "fault enable", int'(ch_enable), 0);
                    check("R10", "fault irq", int'(irq), 1);
                    check("R2", "fault action", int'(log_action), A_SHUT);
                    check("R2", "fault code", int'(log_code), a + m);
                    check("R2", "fault count", int'(log_count), a);
                    step();
                    if (a == m) begin
                        check("R6", "latch state", int'(state_o), S_LATCH);
                        check("R6", "latch enable", int'(ch_enable), 0);
                        check("R10", "latch irq", int'(irq), 1);
                        check("R6", "latch action", int'(log_action), A_LATCH);
                        check("R6", "latch count", int'(log_count), m);
                    end else begin
                        check("R3", "retry state", int'(state_o), S_RETRY);
                        check("R3", "retry action", int'(log_action), A_BACKOFF);
                        check("R10", "retry irq", int'(irq), 0);
                        wait_leave(S_RETRY, n);
                        check("R4", "retry duration", n, iv + 1);
                        check("R4", "after retry state", int'(state_o), S_NORMAL);
                        check("R5", "reenable action", int'(log_action), A_REEN);
                        check("R5", "reenable count", int'(log_count), a + 1);
                        check("R5", "reenable enable", int'(ch_enable), 1);
                    end
                end
                repeat (5) step();
                check("R7", "latch held", int'(state_o), S_LATCH);
                svc_clear = 1'b1;
                step();
                svc_clear = 1'b0;
                check("R7", "clear state", int'(state_o), S_NORMAL);
                check("R7", "clear action", int'(log_action), A_RESUME);
                check("R7", "clear count", int'(log_count), 0);
            end
        end

        // Hold window boundary
        max_attempts = 3'd3; retry_interval = 8'd1; hold_window = 8'd3;
        do_reset();
        pulse_fault(2); step();
        wait_leave(S_RETRY, n);
        repeat (3) step();
        pulse_fault(2);
        check("R5", "fault on last hold cycle keeps count", int'(log_count), 1);
        step();
        wait_leave(S_RETRY, n);
        check("R5", "second attempt count", int'(log_count), 2);
        repeat (4) step();
        pulse_fault(2);
        check("R5", "fault after hold clears count", int'(log_count), 0);

        // Health gating
        max_attempts = 3'd2; retry_interval = 8'd2;
        do_reset();
        pulse_fault(5); step();
        temp_ok = 1'b0;
        repeat (10) step();
        check("R4", "temp low holds retry", int'(state_o), S_RETRY);
        temp_ok = 1'b1; v_ok = 1'b0;
        repeat (3) step();
        check("R4", "supply low holds retry", int'(state_o), S_RETRY);
        v_ok = 1'b1;
        step();
        check("R4", "healthy retry exit", int'(state_o), S_NORMAL);

        // Auto recovery from the latch
        max_attempts = 3'd0; retry_interval = 8'd3;
        do_reset();
        auto_recover = 1'b1; temp_ok = 1'b0;
        pulse_fault(7); step();
        check("R6", "zero budget latches", int'(state_o), S_LATCH);
        repeat (10) step();
        check("R7", "auto latch waits for health", int'(state_o), S_LATCH);
        temp_ok = 1'b1;
        step();
        check("R7", "auto exit state", int'(state_o), S_NORMAL);
        check("R7", "auto exit action", int'(log_action), A_RESUME);
        pulse_fault(7); step();
        wait_leave(S_LATCH, n);
        check("R7", "auto exit duration", n, 4);

        // Degraded path and ignored inputs
        do_reset();
        policy_degrade = 1'b1;
        svc_clear = 1'b1;
        step();
        svc_clear = 1'b0;
        check("R8", "clear ignored in normal", int'(state_o), S_NORMAL);
        check("R8", "no record for ignored clear", int'(log_valid), 0);
        pulse_fault(9); step();
        check("R3", "degraded state", int'(state_o), S_DEGR);
        check("R3", "degraded enable", int'(ch_enable), 1);
        check("R3", "degraded derate", int'(derate_req), 1);
        check("R3", "degraded action", int'(log_action), A_DERATE);
        check("R10", "degraded irq", int'(irq), 0);
        pulse_fault(9);
        check("R8", "fault ignored in degraded", int'(state_o), S_DEGR);
        check("R8", "no record in degraded", int'(log_valid), 0);
        svc_clear = 1'b1;
        step();
        svc_clear = 1'b0;
        check("R8", "degraded clear state", int'(state_o), S_NORMAL);
        check("R8", "degraded clear derate", int'(derate_req), 0);

        max_attempts = 3'd1; retry_interval = 8'd10;
        do_reset();
        pulse_fault(3); step();
        svc_clear = 1'b1;
        step();
        svc_clear = 1'b0;
        check("R8", "clear ignored in retry", int'(state_o), S_RETRY);
        check("R8", "clear ignored enable", int'(ch_enable), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule